// File: doc/BRIEF.md
# SAR Converter Control Core

This block is the digital side of a 10-bit successive-approximation converter that sits on a simple parallel processor bus. A host writes one 10-bit configuration word. That single write selects the input channel or channels and the operating options, and it also starts a conversion. The core then runs a fixed sequence: a short acquisition window, a hold strobe, two settling cycles, and then the bit decisions. It drives a trial code toward the comparison network and reads back a one-bit comparator verdict. The finished code is stored in two's complement form.

The core can convert one channel, or two channels that are sampled together and converted one after the other, each into its own result register. In the paired case, consecutive reads alternate between the two results. An active-low status pin works either as a busy indicator or as a completion interrupt. Any bus access that arrives during a conversion abandons that conversion. A power-down option stops new conversions and keeps the stored results readable. A half-scale self-test replaces the selected input with the reference level.

The analog parts are outside this block: the comparator, the reference, the track-and-hold and the settling. They appear only as the channel select, reference select, hold strobe, trial code and comparator signals.

Top module: `sar_ctl_core`

## Requirements
- R1: After reset the configuration word is zero, both result registers read 0x000, the status pin is high, and the hold strobe, output enable and reference select are low.
- R2: A configuration word on `din` is latched on the clock after `wr_n` rises while `cs_n` is low. A strobe with `cs_n` high changes nothing. An accepted write with bit 8 clear starts acquisition, and `hold` is then high for exactly one cycle, sampled 5 clock edges after the write edge (counting that edge as 1).
- R3: Bit decisions follow a fixed schedule. The MSB is decided 2 cycles after the hold cycle and the next bit 2 cycles later. Each remaining bit takes one cycle. A single conversion ends with the status pin back high 19 edges after the write edge, in busy mode.
- R4: The SAR drives an offset-binary trial code and keeps each tested bit when `comp` is high. The stored result is the final code with its MSB inverted. So input code 0x3FF gives 0x1FF, 0x000 gives 0x200 and midscale 0x200 gives 0x000.
- R5: Bits [2:0] select the first channel and bits [5:3] the second, both shown on `chan_sel`. With bit 6 set, the second conversion follows the first without a second hold pulse. Results go to register 1 and then register 2, and the pair ends 33 edges after the write edge.
- R6: `dout_oe` is high only while `cs_n` and `rd_n` are both low. In single mode every read returns register 1. In paired mode reads alternate between register 1 and register 2, and each new conversion start makes the next read return register 1.
- R7: With bit 9 clear the status pin is low while a conversion or pair runs. With bit 9 set it goes low when the conversion or pair completes and stays low until a falling edge of `wr_n` or `rd_n` with `cs_n` low.
- R8: A read that starts during a conversion abandons it at once. The status pin goes high, no result register is written and no conversion resumes.
- R9: A write during a conversion abandons it on the falling edge of `wr_n` (the status pin goes high), then starts a fresh sequence from its rising edge using the new word.
- R10: A write with bit 8 set starts no conversion and leaves the results readable. A later write with bit 8 clear starts a conversion whose result replaces the stored value.
- R11: With bit 7 set, `ref_sel` is high and the reference (midscale) level is converted instead of the channels, giving 0x000. Bit 6 still selects one or two conversions.
- R12: A channel field value of NUM_CH or more is wrapped modulo NUM_CH on `chan_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 10 | Configuration word from the bus |
| dout | output | RES_W | Result read port |
| dout_oe | output | 1 | Drive enable for the read port |
| stat_n | output | 1 | Busy or interrupt status, active low |
| chan_sel | output | CH_W | Channel under conversion |
| ref_sel | output | 1 | Convert the reference level instead of a channel |
| hold | output | 1 | One-cycle hold strobe to the track-and-hold |
| trial_code | output | RES_W | Offset-binary trial code for the comparison network |
| comp | input | 1 | Comparator verdict: input at or above trial code |

## Verification
The checker watches, on every cycle, that the hold strobe is a single-cycle pulse and that a read landing during a conversion leaves the sequencer idle on the next cycle. It also checks that the result registers change only on a completion cycle, that the interrupt pin can fall only as a conversion ends, and that the channel select never leaves its range. The exact cycle counts of the decision schedule, the coded results for each input, the read alternation, the restart after a write abort, and the power-down behaviour all depend on the whole sequence. Only the bench scenarios show them: the bench models a comparator against per-channel input codes and counts edges from the write.

// File: rtl/sarc_pkg.sv
// Shared constants and types for the SAR control core.
// Assumes the configuration word is always 10 bits; field positions are fixed
// because the sequencer and channel mux decode them directly.
package sarc_pkg;
    localparam int CFG_W    = 10;
    localparam int CH_FLD_W = 3;
    localparam int B_CHA    = 0;   // first channel field
    localparam int B_CHB    = 3;   // second channel field
    localparam int B_DUAL   = 6;   // 1: two conversions
    localparam int B_HALF   = 7;   // 1: convert reference level
    localparam int B_PD     = 8;   // 1: power-down, no start
    localparam int B_INT    = 9;   // 1: status pin as interrupt

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sarc_busif.sv
// Bus front end: samples the strobes on the converter clock, derives edge
// events and holds the write-only configuration register.
// Assumes strobes are already synchronous to clk and change away from its edge.
module sarc_busif
    import sarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] cfg,
    output logic             start,
    output logic             wr_fall,
    output logic             rd_fall,
    output logic             rd_end,
    output logic             rd_act
);
    logic wr_q;
    logic rd_q;
    logic rd_act_q;
    logic wr_rise;
    logic sel;

    assign sel     = !cs_n;
    assign rd_act  = sel && !rd_n;
    assign wr_fall = sel && !wr_n && wr_q;
    assign wr_rise = sel && wr_n && !wr_q;
    assign rd_fall = sel && !rd_n && rd_q;
    assign rd_end  = rd_act_q && !rd_act;
    assign start   = wr_rise && !din[B_PD];

    // Track previous strobe levels and latch the configuration on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b1;
            rd_q     <= 1'b1;
            rd_act_q <= 1'b0;
            cfg      <= '0;
        end else begin
            wr_q     <= wr_n;
            rd_q     <= rd_n;
            rd_act_q <= rd_act;
            if (wr_rise) begin
                cfg <= din;
            end
        end
    end
endmodule

// File: rtl/sarc_seq.sv
// Conversion sequencer and successive-approximation register.
// Runs acquisition, a hold cycle, settling and one bit decision per scheduled
// step; chains a second conversion when dual mode is set.
// Assumes start and abort never coincide.
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int ACQ_CYC = 4,
    parameter int SETTLE  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             dual,
    input  logic             comp,
    output logic             hold,
    output logic             pass2,
    output logic             active,
    output logic [RES_W-1:0] trial,
    output logic             res_wr,
    output logic             res_sel,
    output logic [RES_W-1:0] res_data,
    output logic             pair_done
);
    localparam int LAST_DEC  = SETTLE + RES_W;
    localparam int LAST_STEP = LAST_DEC + 1;
    localparam int STEP_W    = $clog2(LAST_STEP + 1);
    localparam int ACQ_W     = $clog2(ACQ_CYC + 1);
    localparam logic [RES_W-1:0] ONE = {{(RES_W-1){1'b0}}, 1'b1};

    seq_state_e       state;
    logic [ACQ_W-1:0] acq_cnt;
    logic [STEP_W-1:0] step;
    logic             pass2_q;
    logic [RES_W-1:0] ob;
    logic             in_conv;
    logic             decide;
    int               st;
    int               bit_k;

    assign in_conv = (state == SEQ_CONV);

    // Map the current step to the bit under test and whether it is decided now.
    always_comb begin
        st     = int'(step);
        decide = 1'b0;
        bit_k  = 0;
        if (st <= SETTLE) begin
            bit_k  = RES_W - 1;
            decide = (st == SETTLE);
        end else if (st <= SETTLE + 2) begin
            bit_k  = RES_W - 2;
            decide = (st == SETTLE + 2);
        end else if (st <= LAST_DEC) begin
            bit_k  = LAST_DEC - st;
            decide = 1'b1;
        end
    end

    assign trial     = (in_conv && st <= LAST_DEC) ? (ob | (ONE << bit_k)) : ob;
    assign res_wr    = in_conv && (st == LAST_STEP);
    assign res_sel   = pass2_q;
    assign res_data  = {~ob[RES_W-1], ob[RES_W-2:0]};
    assign pair_done = res_wr && (!dual || pass2_q);
    assign hold      = in_conv && (step == '0) && !pass2_q;
    assign active    = (state != SEQ_IDLE);
    assign pass2     = pass2_q;

    // Advance acquisition, settling and bit decisions; handle abort and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            acq_cnt <= '0;
            step    <= '0;
            pass2_q <= 1'b0;
            ob      <= '0;
        end else if (abort) begin
            state   <= SEQ_IDLE;
            step    <= '0;
            pass2_q <= 1'b0;
            ob      <= '0;
        end else if (start) begin
            state   <= SEQ_ACQ;
            acq_cnt <= '0;
            step    <= '0;
            pass2_q <= 1'b0;
            ob      <= '0;
        end else begin
            case (state)
                SEQ_ACQ: begin
                    if (acq_cnt == ACQ_W'(ACQ_CYC - 1)) begin
                        state <= SEQ_CONV;
                        step  <= '0;
                    end else begin
                        acq_cnt <= acq_cnt + 1'b1;
                    end
                end
                SEQ_CONV: begin
                    if (decide) begin
                        ob[bit_k] <= comp;
                    end
                    if (res_wr) begin
                        ob   <= '0;
                        step <= '0;
                        if (dual && !pass2_q) begin
                            pass2_q <= 1'b1;
                        end else begin
                            state   <= SEQ_IDLE;
                            pass2_q <= 1'b0;
                        end
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sarc_resbank.sv
// Two result registers and the alternating read pointer.
// Assumes the pointer only matters in dual mode; a start rewinds it.
module sarc_resbank #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [RES_W-1:0] wdata,
    input  logic             clr_ptr,
    input  logic             adv_ptr,
    input  logic             dual,
    output logic [RES_W-1:0] res1,
    output logic [RES_W-1:0] res2,
    output logic             rd_sel
);
    localparam int SLOTS = 2;

    logic [RES_W-1:0] slot [SLOTS];
    logic             ptr;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Store a finished code into the slot chosen by the sequencer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (int'(wr_sel) == g)) begin
                slot[g] <= wdata;
            end
        end
    end

    // Rewind on a start, step to the other slot after each dual-mode read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= 1'b0;
        end else if (clr_ptr) begin
            ptr <= 1'b0;
        end else if (adv_ptr && dual) begin
            ptr <= ~ptr;
        end
    end

    assign res1   = slot[0];
    assign res2   = slot[1];
    assign rd_sel = dual && ptr;
endmodule

// File: rtl/sar_ctl_core.sv
// Top of the SAR converter control core: bus front end, sequencer, result
// bank, channel select and the two-mode status pin.
// Assumes bus strobes are synchronous to the converter clock.
module sar_ctl_core
    import sarc_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int NUM_CH  = 8,
    parameter int ACQ_CYC = 4,
    parameter int SETTLE  = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [CFG_W-1:0] din,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe,
    output logic             stat_n,
    output logic [CH_W-1:0]  chan_sel,
    output logic             ref_sel,
    output logic             hold,
    output logic [RES_W-1:0] trial_code,
    input  logic             comp
);
    logic [CFG_W-1:0] cfg_q;
    logic             start;
    logic             wr_fall;
    logic             rd_fall;
    logic             rd_end;
    logic             rd_act;
    logic             pass2;
    logic             seq_active;
    logic             res_wr;
    logic             res_sel;
    logic [RES_W-1:0] res_data;
    logic             pair_done;
    logic [RES_W-1:0] res1;
    logic [RES_W-1:0] res2;
    logic             rd_sel;
    logic             int_flag;
    logic             int_mode;
    logic             dual;
    logic [CH_W-1:0]  ch_a;
    logic [CH_W-1:0]  ch_b;

    sarc_busif i_busif (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .din     (din),
        .cfg     (cfg_q),
        .start   (start),
        .wr_fall (wr_fall),
        .rd_fall (rd_fall),
        .rd_end  (rd_end),
        .rd_act  (rd_act)
    );

    assign dual     = cfg_q[B_DUAL];
    assign int_mode = cfg_q[B_INT];

    sarc_seq #(
        .RES_W   (RES_W),
        .ACQ_CYC (ACQ_CYC),
        .SETTLE  (SETTLE)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (wr_fall || rd_fall),
        .dual      (dual),
        .comp      (comp),
        .hold      (hold),
        .pass2     (pass2),
        .active    (seq_active),
        .trial     (trial_code),
        .res_wr    (res_wr),
        .res_sel   (res_sel),
        .res_data  (res_data),
        .pair_done (pair_done)
    );

    sarc_resbank #(
        .RES_W (RES_W)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .wr_sel  (res_sel),
        .wdata   (res_data),
        .clr_ptr (start),
        .adv_ptr (rd_end),
        .dual    (dual),
        .res1    (res1),
        .res2    (res2),
        .rd_sel  (rd_sel)
    );

    // Wrap both channel fields into the supported channel count.
    always_comb begin
        ch_a = CH_W'(int'(cfg_q[B_CHA +: CH_FLD_W]) % NUM_CH);
        ch_b = CH_W'(int'(cfg_q[B_CHB +: CH_FLD_W]) % NUM_CH);
    end

    assign chan_sel = pass2 ? ch_b : ch_a;
    assign ref_sel  = cfg_q[B_HALF];
    assign dout     = rd_sel ? res2 : res1;
    assign dout_oe  = rd_act;

    // Interrupt flag: set when a conversion or pair completes, cleared by a strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
        end else if (wr_fall || rd_fall) begin
            int_flag <= 1'b0;
        end else if (pair_done) begin
            int_flag <= 1'b1;
        end
    end

    assign stat_n = int_mode ? !int_flag : !seq_active;
endmodule

// File: rtl/sar_ctl_core_chk.sv
// Property checker for sar_ctl_core, attached with bind.
// Assumes the names it is connected to exist inside the top module.
module sar_ctl_core_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             rd_n,
    input logic             hold,
    input logic             stat_n,
    input logic             int_mode,
    input logic             active,
    input logic             res_wr,
    input logic [CH_W-1:0]  chan_sel,
    input logic [RES_W-1:0] res1,
    input logic [RES_W-1:0] res2
);
    // R2: the hold strobe never lasts more than one cycle
    a_r2_hold_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);

    // R8: a read starting on the bus leaves the sequencer idle
    a_r8_read_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && $past(rd_n)) |=> !active);

    // R6: result registers change only on a completion cycle
    a_r6_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !res_wr |=> ($stable(res1) && $stable(res2)));

    // R7: in interrupt mode the pin falls only as a conversion ends
    a_r7_int_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && $fell(stat_n)) |-> !active);

    // R12: channel select stays inside the supported count
    a_r12_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_sel) < NUM_CH);
endmodule

bind sar_ctl_core sar_ctl_core_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .RES_W  (RES_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .hold     (hold),
    .stat_n   (stat_n),
    .int_mode (int_mode),
    .active   (seq_active),
    .res_wr   (res_wr),
    .chan_sel (chan_sel),
    .res1     (res1),
    .res2     (res2)
);

// File: tb/test_sar_ctl_core.sv
module test_sar_ctl_core;
    localparam int NCH = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [9:0] din = '0;
    logic [9:0] dout;
    logic       dout_oe;
    logic       stat_n;
    logic [2:0] chan_sel;
    logic       ref_sel;
    logic       hold;
    logic [9:0] trial_code;
    logic       comp;

    logic [9:0] vin [NCH];
    logic [9:0] th  [64];
    logic [2:0] chh [64];
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    sar_ctl_core #(.NUM_CH(NCH)) i_sar_ctl_core (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .din(din), .dout(dout), .dout_oe(dout_oe), .stat_n(stat_n),
        .chan_sel(chan_sel), .ref_sel(ref_sel), .hold(hold),
        .trial_code(trial_code), .comp(comp)
    );

    // Comparator model: input code at or above the trial code.
    always_comb begin
        if (ref_sel) comp = (10'd512 >= trial_code);
        else if (int'(chan_sel) < NCH) comp = (vin[chan_sel] >= trial_code);
        else comp = 1'b0;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input logic [9:0] v);
        return int'(v ^ 10'h200);
    endfunction

    bit wr_stat;
    task automatic bus_write(input logic [9:0] d);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = d;
        @(negedge clk); wr_stat = stat_n; wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; din = '0;
    endtask

    task automatic bus_read(output logic [9:0] d, output bit oe, output bit st);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); d = dout; oe = dout_oe; st = stat_n; rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    // Count edges from the write edge (as 1) until stat_n reaches lvl.
    task automatic watch(input bit lvl, output int n, output int nh, output int hc);
        n = 1; nh = 0; hc = 0;
        while (stat_n !== lvl && n < 80) begin
            if (hold === 1'b1) begin hc++; if (nh == 0) nh = n; end
            if (n < 64) begin th[n] = trial_code; chh[n] = chan_sel; end
            @(negedge clk); n++;
        end
    endtask

    task automatic quiet(input int cyc, output int bad);
        bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (hold !== 1'b0 || stat_n !== 1'b1) bad++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int n, nh, hc, bad, a, b, du, hs, e1, e2;
        logic [9:0] d, cfg;
        bit oe, st;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) vin[i] = 10'(i * 100);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "stat_n", int'(stat_n), 1);
        chk("R1", "dout_oe", int'(dout_oe), 0);
        chk("R1", "hold", int'(hold), 0);
        chk("R1", "ref_sel", int'(ref_sel), 0);
        chk("R1", "chan_sel", int'(chan_sel), 0);
        bus_read(d, oe, st);
        chk("R1", "result after reset", int'(d), 0);
        chk("R6", "oe during read", int'(oe), 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R6", "oe with cs high", int'(dout_oe), 0);
        rd_n = 1'b1;

        // Single conversion, full-scale input: timing and trial schedule.
        vin[2] = 10'h3FF;
        bus_write(10'h002);
        chk("R5", "first channel select", int'(chan_sel), 2);
        watch(1'b1, n, nh, hc);
        chk("R3", "single length", n, 19);
        chk("R2", "hold edge", nh, 5);
        chk("R2", "hold count", hc, 1);
        chk("R3", "trial before msb", int'(th[7]), 'h200);
        chk("R3", "trial after msb", int'(th[8]), 'h300);
        chk("R3", "trial held during settle", int'(th[9]), 'h300);
        chk("R3", "trial after bit8", int'(th[10]), 'h380);
        chk("R3", "trial after bit7", int'(th[11]), 'h3C0);
        bus_read(d, oe, st);
        chk("R4", "positive full scale", int'(d), 'h1FF);
        bus_read(d, oe, st);
        chk("R6", "single repeat read", int'(d), 'h1FF);

        vin[0] = 10'h000;
        bus_write(10'h000); watch(1'b1, n, nh, hc);
        bus_read(d, oe, st);
        chk("R4", "negative full scale", int'(d), 'h200);
        vin[0] = 10'h200;
        bus_write(10'h000); watch(1'b1, n, nh, hc);
        bus_read(d, oe, st);
        chk("R4", "midscale", int'(d), 'h000);

        // Paired conversion.
        vin[1] = 10'h123; vin[4] = 10'h2AB;
        bus_write(10'(32'h40 | (4 << 3) | 1));
        watch(1'b1, n, nh, hc);
        chk("R5", "pair length", n, 33);
        chk("R5", "single hold per pair", hc, 1);
        chk("R5", "first pass channel", int'(chh[10]), 1);
        chk("R5", "second pass channel", int'(chh[25]), 4);
        bus_read(d, oe, st); chk("R6", "pair read 1", int'(d), 'h323);
        bus_read(d, oe, st); chk("R6", "pair read 2", int'(d), 'h0AB);
        bus_read(d, oe, st); chk("R6", "pair read 3", int'(d), 'h323);
        bus_read(d, oe, st); chk("R6", "pair read 4", int'(d), 'h0AB);

        // Channel wrap: field 7 with six channels selects channel 1.
        bus_write(10'h007);
        chk("R12", "wrapped channel", int'(chan_sel), 1);
        watch(1'b1, n, nh, hc);
        bus_read(d, oe, st);
        chk("R12", "wrapped result", int'(d), 'h323);

        // Half-scale test with pair.
        bus_write(10'(32'h80 | 32'h40 | (3 << 3) | 2));
        chk("R11", "ref_sel", int'(ref_sel), 1);
        watch(1'b1, n, nh, hc);
        chk("R11", "pair length in test", n, 33);
        bus_read(d, oe, st); chk("R11", "test result 1", int'(d), 0);
        bus_read(d, oe, st); chk("R11", "test result 2", int'(d), 0);

        // Interrupt mode.
        vin[3] = 10'h050;
        bus_write(10'(32'h200 | 3));
        watch(1'b0, n, nh, hc);
        chk("R7", "interrupt edge", n, 19);
        repeat (5) @(negedge clk);
        chk("R7", "interrupt held", int'(stat_n), 0);
        bus_read(d, oe, st);
        chk("R7", "read clears interrupt", int'(st), 1);
        chk("R7", "interrupt result", int'(d), 'h250);
        chk("R7", "stays clear", int'(stat_n), 1);
        bus_write(10'(32'h200 | 3)); watch(1'b0, n, nh, hc);
        bus_write(10'(32'h200 | 3));
        chk("R7", "write clears interrupt", int'(wr_stat), 1);
        watch(1'b0, n, nh, hc);
        chk("R7", "second interrupt edge", n, 19);

        // Read abort.
        vin[3] = 10'h111;
        bus_write(10'h003);
        repeat (6) @(negedge clk);
        bus_read(d, oe, st);
        chk("R8", "status after read abort", int'(st), 1);
        quiet(30, bad);
        chk("R8", "no resumed conversion", bad, 0);
        bus_read(d, oe, st);
        chk("R8", "result kept", int'(d), 'h250);

        // Write abort and restart.
        vin[5] = 10'h3A0;
        bus_write(10'h001);
        repeat (6) @(negedge clk);
        bus_write(10'h005);
        chk("R9", "status during abort write", int'(wr_stat), 1);
        watch(1'b1, n, nh, hc);
        chk("R9", "restart length", n, 19);
        bus_read(d, oe, st);
        chk("R9", "restart result", int'(d), 'h1A0);

        // Power-down.
        vin[2] = 10'h0F0;
        bus_write(10'h102);
        quiet(25, bad);
        chk("R10", "no conversion in power-down", bad, 0);
        bus_read(d, oe, st);
        chk("R10", "result kept in power-down", int'(d), 'h1A0);
        bus_write(10'h002);
        watch(1'b1, n, nh, hc);
        chk("R10", "wake conversion length", n, 19);
        bus_read(d, oe, st);
        chk("R10", "wake result", int'(d), 'h2F0);

        // Write with chip select high is ignored.
        @(negedge clk); din = 10'h041; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); din = '0;
        quiet(25, bad);
        chk("R2", "deselected write starts nothing", bad, 0);
        bus_read(d, oe, st); chk("R2", "config unchanged read 1", int'(d), 'h2F0);
        bus_read(d, oe, st); chk("R2", "config unchanged read 2", int'(d), 'h2F0);

        // Random mix.
        for (int it = 0; it < 30; it++) begin
            for (int c = 0; c < NCH; c++) vin[c] = 10'($urandom % 1024);
            a  = int'($urandom % 8);
            b  = int'($urandom % 8);
            du = int'($urandom % 2);
            hs = (($urandom % 5) == 0) ? 1 : 0;
            cfg = 10'((hs << 7) | (du << 6) | (b << 3) | a);
            e1 = hs ? 0 : code_of(vin[a % NCH]);
            e2 = hs ? 0 : code_of(vin[b % NCH]);
            bus_write(cfg);
            watch(1'b1, n, nh, hc);
            chk("R3", "random length", n, du ? 33 : 19);
            bus_read(d, oe, st);
            chk("R4", "random first result", int'(d), e1);
            if (du != 0) begin
                bus_read(d, oe, st);
                chk("R5", "random second result", int'(d), e2);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule